// File: doc/BRIEF.md
# Interval Down-Counter Timer

A 32-bit interval timer on a simple single-cycle register bus. A down-counter steps once per pulse of a selected clock-enable input: a bus-clock enable, a fast reference enable or a slow 32768 Hz reference enable. Source 0 selects none of them. At zero the counter either reloads from the load register (periodic use) or wraps to all ones (free-running time base). For a time base, software keeps 0xFFFFFFFF in the load register and forms an up-count as 0xFFFFFFFF minus the counter value.

When the counter steps onto the compare value, a sticky flag is raised, and it is cleared by writing one to it. An interrupt line is the flag gated by an enable bit. The counter can be preloaded when the timer is enabled, or whenever the load register is written. Three allow bits decide whether counting continues while the stop, wait and debug inputs are high. A self-clearing soft-reset bit resets the counter and the flag, and software polls it until it reads back 0. For event use the load value should stay between 2 and 0xFFFFFFFE ticks.

Register map (byte offsets): 0x00 control, 0x04 status, 0x08 load, 0x0C compare, 0x10 counter (read only). Control fields: bit 0 run, bit 1 load-on-enable, bit 2 interrupt enable, bit 3 reload mode, bit 16 soft reset, bit 17 load-writes-counter, bit 18 run in debug, bit 19 run in wait, bit 21 run in stop, bits 25:24 source select.

Top module: `ivtimer`

## Requirements
- R1: After reset, control, status and compare read 0, load and counter read 0xFFFFFFFF, and irq is 0.
- R2: While control bit 0 is 1, the counter drops by one per pulse of the source chosen by control bits 25:24 (1 = tick_bus, 2 = tick_fast, 3 = tick_slow). Pulses on unselected sources, and every pulse under source 0, leave it unchanged.
- R3: A tick at count 0 loads the load register value when control bit 3 is 1, and 0xFFFFFFFF when it is 0.
- R4: A control write that changes bit 0 from 0 to 1 while writing bit 1 as 1 copies the load register into the counter. Clearing bit 0 stops counting and keeps the count. Re-enabling with bit 1 at 0 keeps the count.
- R5: With control bit 17 at 1, a write to load (0x08) also sets the counter to the written value. With bit 17 at 0, the counter is untouched.
- R6: Status bit 0 sets on a tick that brings the counter to the compare value. It stays set until a status write with bit 0 = 1, and a write with bit 0 = 0 leaves it set. A match in the same cycle as a clear wins.
- R7: irq equals status bit 0 AND control bit 2.
- R8: Counting freezes while stop_in, wait_in or dbg_in is high unless the matching allow bit (21, 19, 18 respectively) is 1.
- R9: A control write with bit 16 = 1 sets the counter to 0xFFFFFFFF and clears status bit 0. Bit 16 then reads 1 for SRST_CYCLES cycles and 0 afterwards, and no tick counts while it reads 1. The other control bits of that write take effect.
- R10: Control reads back only bits 0-3, 17-19, 21 and 24-25 as written, plus bit 16 as the soft-reset busy state. Writes to the counter offset 0x10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_bus | input | 1 | Count enable from the bus clock (source 1) |
| tick_fast | input | 1 | Count enable from the fast reference (source 2) |
| tick_slow | input | 1 | Count enable from the 32768 Hz reference (source 3) |
| stop_in | input | 1 | Stop low-power state indicator |
| wait_in | input | 1 | Wait low-power state indicator |
| dbg_in | input | 1 | Debug halt indicator |
| irq | output | 1 | Compare interrupt |

## Verification
The hardest situation to reach from the ports is a tick that arrives while the soft reset is still busy. The bench issues the soft-reset write and drives a source pulse on the very next cycle, before the busy bit is polled. It then checks that the counter still reads all ones, and that the first tick after busy drops counts normally. A second hard corner is the reload at zero with the compare at 0: the bench steps exactly onto zero, clears the flag, and runs a full period to see it set again.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int IVT_DW = 32;
  typedef logic [IVT_DW-1:0] word_t;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_LOAD = 'h08;
  localparam int OFS_CMP  = 'h0C;
  localparam int OFS_CNT  = 'h10;

  localparam int B_RUN    = 0;
  localparam int B_LDEN   = 1;
  localparam int B_IE     = 2;
  localparam int B_RLD    = 3;
  localparam int B_SRST   = 16;
  localparam int B_LDWR   = 17;
  localparam int B_DBGOK  = 18;
  localparam int B_WAITOK = 19;
  localparam int B_STOPOK = 21;
  localparam int B_SEL    = 24;

  localparam word_t CTRL_KEEP = word_t'((1 << B_RUN) | (1 << B_LDEN) | (1 << B_IE) |
                                        (1 << B_RLD) | (1 << B_LDWR) | (1 << B_DBGOK) |
                                        (1 << B_WAITOK) | (1 << B_STOPOK) | (3 << B_SEL));

  // Next value of the down-counter on one tick
  function automatic word_t ivt_step(input word_t cur, input logic rld, input word_t ld);
    if (cur == '0) return rld ? ld : '1;
    return cur - word_t'(1);
  endfunction
endpackage

// File: rtl/ivt_tick_gate.sv
module ivt_tick_gate (
  input  logic [1:0] sel,
  input  logic       run,
  input  logic       busy,
  input  logic       tick_bus,
  input  logic       tick_fast,
  input  logic       tick_slow,
  input  logic       stop_in,
  input  logic       wait_in,
  input  logic       dbg_in,
  input  logic       stop_ok,
  input  logic       wait_ok,
  input  logic       dbg_ok,
  output logic       frozen,
  output logic       tick
);
  logic [3:0] src;
  assign src    = {tick_slow, tick_fast, tick_bus, 1'b0};
  assign frozen = (stop_in & ~stop_ok) | (wait_in & ~wait_ok) | (dbg_in & ~dbg_ok);
  assign tick   = run & ~busy & ~frozen & src[sel];
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
  import ivt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  srst,
  input  logic  load_now,
  input  word_t load_val,
  input  logic  tick,
  input  logic  rld,
  input  word_t reload_val,
  input  word_t cmp_val,
  output word_t cnt,
  output logic  match_evt
);
  word_t nxt;
  assign nxt       = ivt_step(cnt, rld, reload_val);
  assign match_evt = tick & ~srst & ~load_now & (nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '1;
    else if (srst)     cnt <= '1;
    else if (load_now) cnt <= load_val;
    else if (tick)     cnt <= nxt;
  end

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !srst && !load_now && cnt != '0) |=> cnt == $past(cnt) - word_t'(1));
  // R3
  zero_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !srst && !load_now && cnt == '0) |=> cnt == ($past(rld) ? $past(reload_val) : '1));
endmodule

// File: rtl/ivtimer.sv
module ivtimer
  import ivt_pkg::*;
#(
  parameter int AW          = 5,
  parameter int SRST_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          tick_bus,
  input  logic          tick_fast,
  input  logic          tick_slow,
  input  logic          stop_in,
  input  logic          wait_in,
  input  logic          dbg_in,
  output logic          irq
);
  localparam int SRW = $clog2(SRST_CYCLES + 1);

  word_t          ctrl_q, load_q, cmp_q, cnt;
  logic           flag_q;
  logic [SRW-1:0] busy_cnt;
  logic           busy, tick, frozen, match_evt;
  logic           wr_ctrl, wr_stat, wr_load, wr_cmp;
  logic           srst, run_rise, load_now;
  word_t          load_val;

  assign wr_ctrl = bus_we && (int'(bus_addr) == OFS_CTRL);
  assign wr_stat = bus_we && (int'(bus_addr) == OFS_STAT);
  assign wr_load = bus_we && (int'(bus_addr) == OFS_LOAD);
  assign wr_cmp  = bus_we && (int'(bus_addr) == OFS_CMP);

  assign srst     = wr_ctrl && bus_wdata[B_SRST];
  assign run_rise = wr_ctrl && bus_wdata[B_RUN] && !ctrl_q[B_RUN] && bus_wdata[B_LDEN];
  assign load_now = run_rise || (wr_load && ctrl_q[B_LDWR]);
  assign load_val = wr_load ? bus_wdata : load_q;
  assign busy     = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      load_q   <= '1;
      cmp_q    <= '0;
      busy_cnt <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
      if (wr_load) load_q <= bus_wdata;
      if (wr_cmp)  cmp_q  <= bus_wdata;
      if (srst)      busy_cnt <= SRW'(SRST_CYCLES);
      else if (busy) busy_cnt <= busy_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       flag_q <= 1'b0;
    else if (srst)                    flag_q <= 1'b0;
    else if (match_evt)               flag_q <= 1'b1;
    else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;
  end

  ivt_tick_gate gate_i (
    .sel(ctrl_q[B_SEL +: 2]), .run(ctrl_q[B_RUN]), .busy(busy),
    .tick_bus(tick_bus), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .stop_in(stop_in), .wait_in(wait_in), .dbg_in(dbg_in),
    .stop_ok(ctrl_q[B_STOPOK]), .wait_ok(ctrl_q[B_WAITOK]), .dbg_ok(ctrl_q[B_DBGOK]),
    .frozen(frozen), .tick(tick)
  );

  ivt_counter cnt_i (
    .clk(clk), .rst_n(rst_n), .srst(srst), .load_now(load_now), .load_val(load_val),
    .tick(tick), .rld(ctrl_q[B_RLD]), .reload_val(load_q), .cmp_val(cmp_q),
    .cnt(cnt), .match_evt(match_evt)
  );

  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      OFS_CTRL: bus_rdata = ctrl_q | (word_t'(busy) << B_SRST);
      OFS_STAT: bus_rdata = {31'd0, flag_q};
      OFS_LOAD: bus_rdata = load_q;
      OFS_CMP:  bus_rdata = cmp_q;
      OFS_CNT:  bus_rdata = cnt;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = flag_q & ctrl_q[B_IE];

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag_q);
  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !match_evt) |=> !flag_q);
  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !load_now && !srst) |=> $stable(cnt));
  // R9
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (cnt == '1) && !flag_q && busy);
endmodule

// File: tb/ivtimer_tb_top.sv
module ivtimer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_bus = 0, tick_fast = 0, tick_slow = 0;
  logic        stop_in = 0, wait_in = 0, dbg_in = 0;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  localparam logic [31:0] RUN = 32'h1, LDEN = 32'h2, IE = 32'h4, RLD = 32'h8;
  localparam logic [31:0] SRC1 = 32'h0100_0000, SRC2 = 32'h0200_0000, SRC3 = 32'h0300_0000;

  always #2.5 clk = ~clk;

  ivtimer dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_bus(tick_bus),
    .tick_fast(tick_fast), .tick_slow(tick_slow), .stop_in(stop_in),
    .wait_in(wait_in), .dbg_in(dbg_in), .irq(irq));

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_bus = (which == 1); tick_fast = (which == 2); tick_slow = (which == 3);
      @(negedge clk);
      tick_bus = 0; tick_fast = 0; tick_slow = 0;
    end
  endtask

  task automatic expect_cnt(input logic [31:0] e, input string req);
    logic [31:0] v; rd(5'h10, v); chk(v, e, req);
  endtask

  task automatic expect_stat(input logic [31:0] e, input string req);
    logic [31:0] v; rd(5'h04, v); chk(v, e, req);
  endtask

  task automatic soft_reset(input logic [31:0] keep);
    logic [31:0] v;
    wr(5'h00, keep | 32'h0001_0000);
    for (int i = 0; i < 20; i++) begin
      rd(5'h00, v);
      if (!v[16]) break;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(5'h00, v); chk(v, 32'h0, "R1 ctrl");
    rd(5'h04, v); chk(v, 32'h0, "R1 status");
    rd(5'h08, v); chk(v, 32'hFFFF_FFFF, "R1 load");
    rd(5'h0C, v); chk(v, 32'h0, "R1 compare");
    rd(5'h10, v); chk(v, 32'hFFFF_FFFF, "R1 counter");
    chk({31'd0, irq}, 32'h0, "R1 irq");
  endtask

  task automatic t_count;
    wr(5'h08, 32'd10);
    wr(5'h00, RUN | LDEN | SRC1);
    expect_cnt(32'd10, "R4 load on enable");
    pulse(2, 3);
    expect_cnt(32'd10, "R2 unselected source ignored");
    pulse(1, 3);
    expect_cnt(32'd7, "R2 decrement per tick");
    wr(5'h00, LDEN | SRC1);
    pulse(1, 2);
    expect_cnt(32'd7, "R4 disabled holds count");
    wr(5'h00, RUN | LDEN | SRC1);
    expect_cnt(32'd10, "R4 reload on re-enable");
    pulse(1, 2);
    wr(5'h00, SRC1);
    wr(5'h00, RUN | SRC1);
    expect_cnt(32'd8, "R4 enable without load keeps count");
    wr(5'h00, RUN | SRC3);
    pulse(3, 2);
    expect_cnt(32'd6, "R2 slow source");
    wr(5'h00, RUN);
    pulse(1, 1); pulse(2, 1); pulse(3, 1);
    expect_cnt(32'd6, "R2 source 0 stops");
  endtask

  task automatic t_reload;
    soft_reset(32'h0);
    wr(5'h08, 32'd3);
    wr(5'h0C, 32'd0);
    wr(5'h00, RUN | LDEN | RLD | SRC1);
    pulse(1, 3);
    expect_cnt(32'd0, "R3 reach zero");
    expect_stat(32'd1, "R6 flag at compare 0");
    chk({31'd0, irq}, 32'h0, "R7 irq masked");
    wr(5'h00, RUN | RLD | SRC1 | IE);
    chk({31'd0, irq}, 32'h1, "R7 irq raised");
    pulse(1, 1);
    expect_cnt(32'd3, "R3 reload at zero");
    wr(5'h04, 32'd1);
    expect_stat(32'd0, "R6 write one clears");
    chk({31'd0, irq}, 32'h0, "R7 irq drops");
    pulse(1, 4);
    expect_stat(32'd1, "R6 flag again next period");
    expect_cnt(32'd3, "R3 periodic");
    wr(5'h00, RUN | SRC1);
    wr(5'h04, 32'd1);
    pulse(1, 4);
    expect_cnt(32'hFFFF_FFFF, "R3 wrap without reload");
  endtask

  task automatic t_compare;
    soft_reset(32'h0);
    wr(5'h08, 32'd8);
    wr(5'h0C, 32'd5);
    wr(5'h00, RUN | LDEN | SRC2);
    pulse(2, 2);
    expect_stat(32'd0, "R6 no flag before match");
    pulse(2, 1);
    expect_stat(32'd1, "R6 flag at mid compare");
    wr(5'h04, 32'd0);
    expect_stat(32'd1, "R6 write zero keeps flag");
    pulse(2, 2);
    expect_stat(32'd1, "R6 sticky");
    wr(5'h04, 32'd1);
    expect_stat(32'd0, "R6 cleared");
  endtask

  task automatic t_overwrite;
    logic [31:0] v;
    soft_reset(32'h0);
    wr(5'h00, RUN | SRC1 | 32'h0002_0000);
    wr(5'h08, 32'h100);
    expect_cnt(32'h100, "R5 load write sets counter");
    wr(5'h00, RUN | SRC1);
    wr(5'h08, 32'h200);
    expect_cnt(32'h100, "R5 no overwrite when bit clear");
    rd(5'h08, v); chk(v, 32'h200, "R5 load register");
  endtask

  task automatic t_freeze;
    soft_reset(32'h0);
    wr(5'h00, RUN | SRC1);
    stop_in = 1;
    pulse(1, 2);
    expect_cnt(32'hFFFF_FFFF, "R8 stop freezes");
    wr(5'h00, RUN | SRC1 | 32'h0020_0000);
    pulse(1, 2);
    expect_cnt(32'hFFFF_FFFD, "R8 stop allowed");
    stop_in = 0; wait_in = 1;
    pulse(1, 1);
    expect_cnt(32'hFFFF_FFFD, "R8 wait freezes");
    wr(5'h00, RUN | SRC1 | 32'h0008_0000);
    pulse(1, 1);
    expect_cnt(32'hFFFF_FFFC, "R8 wait allowed");
    wait_in = 0; dbg_in = 1;
    pulse(1, 1);
    expect_cnt(32'hFFFF_FFFC, "R8 debug freezes");
    wr(5'h00, RUN | SRC1 | 32'h0004_0000);
    pulse(1, 1);
    expect_cnt(32'hFFFF_FFFB, "R8 debug allowed");
    dbg_in = 0;
  endtask

  task automatic t_srst;
    logic [31:0] v;
    int cycles;
    soft_reset(32'h0);
    wr(5'h08, 32'd2);
    wr(5'h0C, 32'd0);
    wr(5'h00, RUN | LDEN | SRC1);
    pulse(1, 2);
    expect_stat(32'd1, "R9 setup flag");
    wr(5'h00, RUN | SRC1 | 32'h0001_0000);
    pulse(1, 1);
    expect_cnt(32'hFFFF_FFFF, "R9 counter reset, tick while busy ignored");
    expect_stat(32'd0, "R9 status cleared");
    cycles = 0;
    v = 32'h0001_0000;
    while (v[16] && cycles < 20) begin rd(5'h00, v); cycles++; end
    chk({31'd0, v[16]}, 32'h0, "R9 busy self clears");
    chk(v, RUN | SRC1, "R9 other bits kept");
    pulse(1, 1);
    expect_cnt(32'hFFFF_FFFE, "R9 counts after busy");
  endtask

  task automatic t_readback;
    logic [31:0] a, b;
    soft_reset(32'h0);
    wr(5'h00, 32'hFFFE_FFFF);
    rd(5'h00, a); chk(a, 32'h032E_000F, "R10 control mask");
    rd(5'h10, a);
    wr(5'h10, 32'h1234_5678);
    rd(5'h10, b); chk(b, a, "R10 counter write ignored");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_count;
    t_reload;
    t_compare;
    t_overwrite;
    t_freeze;
    t_srst;
    t_readback;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule